// File: doc/BRIEF.md
# Coalescing Cache Access Queue

This block sits in front of a cache or memory level and holds incoming per-work-item requests until the level below can accept them. Each request carries a byte address, a direction (read or write) and a requester tag. When the oldest entry is offered downstream, the queue also takes in every entry directly behind it that falls in the same 64-byte block and has the same direction. The whole group leaves as one block access, together with a mask that has one bit set for each requester folded into it.

Writes are acknowledged to their requester in the same cycle they are enqueued, so the issuing pipeline never waits on the memory. Reads are tracked after issue in a small in-order list of requester masks. When the level below signals a read response, every requester of the oldest outstanding read access is released together. When all entries are in use, the request input is back-pressured.

Top module: `coalq`

## Requirements
- R1: After reset the queue is empty: `reqReady` is 1, `accValid` is 0 and `rdDoneValid` is 0.
- R2: The block address `accBlock` is the request address shifted right by 6 bits. The low 6 bits do not keep requests in the same block apart.
- R3: The queue holds 16 entries. With 16 stored, `reqReady` is 0, a presented request is not taken and no write acknowledge is given for it.
- R4: A run of consecutive entries at the head with the same block and the same direction leaves as one access. `accMask` is the OR of `1 << tag` over the run, and all of those entries are removed together.
- R5: A run ends at the first entry that differs in block or direction. A later entry that matches the head again is not merged past it, and accesses leave in enqueue order.
- R6: A write is acknowledged on its enqueue cycle: `wrAckValid` is 1 and `wrAckTag` equals the request tag. An enqueued read gives no acknowledge.
- R7: While `accValid` is 1 and `accReady` is 0, `accBlock` and `accWrite` hold. `accMask` may only gain bits, as matching requests arriving behind the run join it.
- R8: Each issued read access records its mask. A cycle with `rspValid` high raises `rdDoneValid` with `rdDoneMask` equal to the oldest unanswered read's mask, and the reads are answered in issue order. A response with no read outstanding is ignored and leaves the record untouched.
- R9: At most 4 read accesses are outstanding. A read at the head is held (`accValid` 0) until a response frees a slot.
- R10: A write at the head issues regardless of how many reads are outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Queue can take a request |
| reqAddr | input | 32 | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTag | input | 4 | Requester identifier |
| wrAckValid | output | 1 | Write accepted this cycle |
| wrAckTag | output | 4 | Tag of the acknowledged write |
| accValid | output | 1 | Block access offered downstream |
| accReady | input | 1 | Downstream takes the access |
| accBlock | output | 26 | Block address of the access |
| accWrite | output | 1 | Direction of the access |
| accMask | output | 16 | One bit per merged requester tag |
| rspValid | input | 1 | Read response from the level below |
| rdDoneValid | output | 1 | Read requesters released |
| rdDoneMask | output | 16 | Requesters of the answered read |

## Verification
The bench uses the default build: 64-byte blocks, 16 entries, 4-bit tags and four outstanding reads. That build is small enough to sweep every run length from one to the full queue depth in both directions, each followed by a breaking entry. The sweep reaches the full-queue back-pressure corner and the all-ones mask. Because the outstanding-read limit is only four, the bench can also drive the list of pending reads to full and hold a write behind a stalled read, and check mask growth while the output is stalled.

// File: rtl/coalq_pkg.sv
package coalq_pkg;
  // Strobes from control to datapath, one per state-changing event.
  typedef struct packed {
    logic push;      // store the incoming request
    logic pop;       // remove the run at the head
    logic pendPush;  // record mask of an issued read
    logic pendPop;   // release the oldest recorded read
  } coalq_strobe_t;
endpackage

// File: rtl/coalq_store.sv
module coalq_store
  import coalq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int DEPTH      = 16,
  parameter int TAG_W      = 4,
  parameter int PEND_DEPTH = 4
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  coalq_strobe_t                              st,
  input  logic [ADDR_W-1:0]                          inAddr,
  input  logic                                       inWrite,
  input  logic [TAG_W-1:0]                           inTag,
  input  logic [$clog2(DEPTH+1)-1:0]                 count,
  output logic [ADDR_W-$clog2(BLK_BYTES)-1:0]        headBlock,
  output logic                                       headWrite,
  output logic [$clog2(DEPTH+1)-1:0]                 runLen,
  output logic [(1<<TAG_W)-1:0]                      runMask,
  output logic [(1<<TAG_W)-1:0]                      pendMask
);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MASK_W = 1 << TAG_W;
  localparam int PPTR_W = $clog2(PEND_DEPTH);

  logic [BLK_W-1:0]  blkMem [DEPTH];
  logic              dirMem [DEPTH];
  logic [TAG_W-1:0]  tagMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  logic [MASK_W-1:0] pendMem [PEND_DEPTH];
  logic [PPTR_W-1:0] pendWrPtr, pendRdPtr;

  always_ff @(posedge clk) begin
    if (st.push) begin
      blkMem[wrPtr] <= inAddr[ADDR_W-1:OFF_W];
      dirMem[wrPtr] <= inWrite;
      tagMem[wrPtr] <= inTag;
    end
    if (st.pendPush) pendMem[pendWrPtr] <= runMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      pendWrPtr <= '0;
      pendRdPtr <= '0;
    end else begin
      if (st.push)     wrPtr     <= wrPtr + PTR_W'(1);
      if (st.pop)      rdPtr     <= rdPtr + runLen[PTR_W-1:0];
      if (st.pendPush) pendWrPtr <= pendWrPtr + PPTR_W'(1);
      if (st.pendPop)  pendRdPtr <= pendRdPtr + PPTR_W'(1);
    end
  end

  assign headBlock = blkMem[rdPtr];
  assign headWrite = dirMem[rdPtr];
  assign pendMask  = pendMem[pendRdPtr];

  // Run scan: extend from the head until the first mismatch.
  always_comb begin
    logic             going;
    logic [PTR_W-1:0] idx;
    runLen  = '0;
    runMask = '0;
    going   = 1'b0;
    idx     = rdPtr;
    if (count != '0) begin
      runLen  = CNT_W'(1);
      runMask = MASK_W'(1) << tagMem[rdPtr];
      going   = 1'b1;
    end
    for (int i = 1; i < DEPTH; i++) begin
      idx = rdPtr + PTR_W'(i);
      if (going && (i < int'(count)) &&
          (blkMem[idx] == blkMem[rdPtr]) && (dirMem[idx] == dirMem[rdPtr])) begin
        runLen  = runLen + CNT_W'(1);
        runMask = runMask | (MASK_W'(1) << tagMem[idx]);
      end else begin
        going = 1'b0;
      end
    end
  end

  assert_mask_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.pendPush |-> (runMask != '0));
endmodule

// File: rtl/coalq_ctrl.sv
module coalq_ctrl
  import coalq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int PEND_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          accReady,
  input  logic                          rspValid,
  input  logic                          headWrite,
  input  logic [$clog2(DEPTH+1)-1:0]    runLen,
  output logic                          reqReady,
  output logic                          accValid,
  output logic                          rdDoneValid,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output coalq_strobe_t                 st
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PCNT_W = $clog2(PEND_DEPTH + 1);

  logic [PCNT_W-1:0] pendCount;
  logic              pendFull, pendAny;

  assign pendFull    = (pendCount == PCNT_W'(PEND_DEPTH));
  assign pendAny     = (pendCount != '0);
  assign reqReady    = (count != CNT_W'(DEPTH));
  assign accValid    = (count != '0) && (headWrite || !pendFull);
  assign rdDoneValid = rspValid && pendAny;

  always_comb begin
    st.push     = reqValid && reqReady;
    st.pop      = accValid && accReady;
    st.pendPush = st.pop && !headWrite;
    st.pendPop  = rdDoneValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      pendCount <= '0;
    end else begin
      count <= count + (st.push ? CNT_W'(1) : '0) - (st.pop ? runLen : '0);
      pendCount <= pendCount + (st.pendPush ? PCNT_W'(1) : '0)
                             - (st.pendPop ? PCNT_W'(1) : '0);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_pend_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PCNT_W'(PEND_DEPTH));
  assert_run_bounds_R4: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (runLen != '0) && (runLen <= count));
endmodule

// File: rtl/coalq.sv
module coalq
  import coalq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int DEPTH      = 16,
  parameter int TAG_W      = 4,
  parameter int PEND_DEPTH = 4,
  localparam int BLK_W     = ADDR_W - $clog2(BLK_BYTES),
  localparam int MASK_W    = 1 << TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              wrAckValid,
  output logic [TAG_W-1:0]  wrAckTag,
  output logic              accValid,
  input  logic              accReady,
  output logic [BLK_W-1:0]  accBlock,
  output logic              accWrite,
  output logic [MASK_W-1:0] accMask,
  input  logic              rspValid,
  output logic              rdDoneValid,
  output logic [MASK_W-1:0] rdDoneMask
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  coalq_strobe_t    st;
  logic [CNT_W-1:0] count, runLen;
  logic             headWrite;

  coalq_ctrl #(.DEPTH(DEPTH), .PEND_DEPTH(PEND_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accReady(accReady),
    .rspValid(rspValid), .headWrite(headWrite), .runLen(runLen),
    .reqReady(reqReady), .accValid(accValid), .rdDoneValid(rdDoneValid),
    .count(count), .st(st)
  );

  coalq_store #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DEPTH(DEPTH),
                .TAG_W(TAG_W), .PEND_DEPTH(PEND_DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .st(st), .inAddr(reqAddr), .inWrite(reqWrite),
    .inTag(reqTag), .count(count), .headBlock(accBlock), .headWrite(headWrite),
    .runLen(runLen), .runMask(accMask), .pendMask(rdDoneMask)
  );

  assign accWrite   = headWrite;
  assign wrAckValid = st.push && reqWrite;
  assign wrAckTag   = reqTag;

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accReady |=> accValid && $stable(accBlock) && $stable(accWrite)
                              && (($past(accMask) & ~accMask) == '0));
endmodule

// File: tb/coalq_bench.sv
`timescale 1ns/1ps
module coalq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, accReady = 1'b0, rspValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqTag = '0;
  logic        reqReady, wrAckValid, accValid, accWrite, rdDoneValid;
  logic [3:0]  wrAckTag;
  logic [25:0] accBlock;
  logic [15:0] accMask, rdDoneMask;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  coalq u_coalq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqTag(reqTag),
    .wrAckValid(wrAckValid), .wrAckTag(wrAckTag), .accValid(accValid),
    .accReady(accReady), .accBlock(accBlock), .accWrite(accWrite),
    .accMask(accMask), .rspValid(rspValid), .rdDoneValid(rdDoneValid),
    .rdDoneMask(rdDoneMask)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Enqueue one request; checks acknowledge (R6) on the enqueue cycle.
  task automatic enq(input logic [31:0] addr, input logic wr, input logic [3:0] tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqTag = tag;
    #1;
    chk("R3", "reqReady", 32'(reqReady), 32'd1);
    chk("R6", "wrAckValid", 32'(wrAckValid), 32'(wr));
    if (wr) chk("R6", "wrAckTag", 32'(wrAckTag), 32'(tag));
    @(posedge clk); #1 reqValid = 1'b0;
  endtask

  // Accept the offered access and compare it.
  task automatic take(input string req, input logic [25:0] blk,
                      input logic wr, input logic [15:0] mask);
    @(negedge clk); #1;
    chk(req, "accValid", 32'(accValid), 32'd1);
    chk("R2", "accBlock", 32'(accBlock), 32'(blk));
    chk(req, "accWrite", 32'(accWrite), 32'(wr));
    chk("R4", "accMask", 32'(accMask), 32'(mask));
    accReady = 1'b1;
    @(posedge clk); #1 accReady = 1'b0;
  endtask

  task automatic rsp(input logic expValid, input logic [15:0] mask);
    @(negedge clk);
    rspValid = 1'b1; #1;
    chk("R8", "rdDoneValid", 32'(rdDoneValid), 32'(expValid));
    if (expValid) chk("R8", "rdDoneMask", 32'(rdDoneMask), 32'(mask));
    @(posedge clk); #1 rspValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", "reqReady", 32'(reqReady), 32'd1);
    chk("R1", "accValid", 32'(accValid), 32'd0);
    chk("R1", "rdDoneValid", 32'(rdDoneValid), 32'd0);

    // Sweep every run length in both directions (R2, R3, R4, R5).
    for (int dir = 0; dir < 2; dir++) begin
      for (int len = 1; len <= 16; len++) begin
        logic [25:0] blk;
        blk = 26'(len * 4 + dir * 100 + 7);
        for (int i = 0; i < len; i++)
          enq({blk, 6'(i * 4 + dir)}, dir[0], 4'(i));
        if (len < 16) begin
          enq({blk + 26'd1, 6'd0}, dir[0], 4'd0);
        end else begin
          @(negedge clk);
          reqValid = 1'b1; reqAddr = {blk + 26'd1, 6'd0}; reqWrite = 1'b1; reqTag = 4'd9;
          #1;
          chk("R3", "reqReady when full", 32'(reqReady), 32'd0);
          chk("R3", "wrAckValid when full", 32'(wrAckValid), 32'd0);
          @(posedge clk); #1 reqValid = 1'b0;
        end
        take("R4", blk, dir[0], 16'((17'(1) << len) - 17'd1));
        if (dir == 0) rsp(1'b1, 16'((17'(1) << len) - 17'd1));
        if (len < 16) begin
          take("R5", blk + 26'd1, dir[0], 16'd1);
          if (dir == 0) rsp(1'b1, 16'd1);
        end
        @(negedge clk); #1;
        chk("R3", "empty after sweep step", 32'(accValid), 32'd0);
      end
    end

    // R5: A A B A, then A as writes.
    enq(32'h0000_1004, 1'b0, 4'd0);
    enq(32'h0000_1030, 1'b0, 4'd1);
    enq(32'h0000_2000, 1'b0, 4'd2);
    enq(32'h0000_1010, 1'b0, 4'd3);
    enq(32'h0000_1000, 1'b1, 4'd4);
    enq(32'h0000_103c, 1'b1, 4'd5);
    take("R5", 26'h40, 1'b0, 16'h0003); rsp(1'b1, 16'h0003);
    take("R5", 26'h80, 1'b0, 16'h0004); rsp(1'b1, 16'h0004);
    take("R5", 26'h40, 1'b0, 16'h0008); rsp(1'b1, 16'h0008);
    take("R5", 26'h40, 1'b1, 16'h0030);

    // R7: stalled access keeps block and direction, mask grows.
    enq(32'h0000_3000, 1'b1, 4'd2);
    @(negedge clk); #1;
    chk("R7", "stalled block", 32'(accBlock), 32'hc0);
    chk("R7", "stalled mask before", 32'(accMask), 32'h4);
    enq(32'h0000_3020, 1'b1, 4'd7);
    @(negedge clk); #1;
    chk("R7", "stalled valid", 32'(accValid), 32'd1);
    chk("R7", "stalled block after", 32'(accBlock), 32'hc0);
    chk("R7", "stalled dir after", 32'(accWrite), 32'd1);
    take("R7", 26'hc0, 1'b1, 16'h0084);

    // R9 and R10: four reads fill the pending list; a write still goes.
    for (int i = 0; i < 4; i++) enq(32'((i + 16) * 64), 1'b0, 4'(i));
    enq(32'h0000_4000, 1'b1, 4'd5);
    enq(32'h0000_5000, 1'b0, 4'd4);
    for (int i = 0; i < 4; i++) take("R9", 26'(i + 16), 1'b0, 16'(1 << i));
    take("R10", 26'h100, 1'b1, 16'h0020);
    @(negedge clk); #1;
    chk("R9", "read held when pending full", 32'(accValid), 32'd0);
    rsp(1'b1, 16'h0001);
    take("R9", 26'h140, 1'b0, 16'h0010);
    rsp(1'b1, 16'h0002);
    rsp(1'b1, 16'h0004);
    rsp(1'b1, 16'h0008);
    rsp(1'b1, 16'h0010);

    // R8: response with nothing outstanding is ignored.
    rsp(1'b0, 16'h0);
    enq(32'h0000_6000, 1'b0, 4'd11);
    take("R8", 26'h180, 1'b0, 16'h0800);
    rsp(1'b1, 16'h0800);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule